// File: doc/BRIEF.md
# Software Interrupt Execute Unit

This unit executes the interrupt-related operations of a small 16-bit processor. When the decoder presents a software interrupt, the unit sends the program counter to a fixed vector, saves the address of the following instruction, and records a 6-bit event number taken from the instruction immediate. It also keeps the interrupt-enable state and forces the register write for that instruction off. An external interrupt request is taken only while interrupts are enabled. It uses the same vector, returns a one-cycle acknowledge, and captures the requester's event word while that acknowledge is high.

Two companion operations complete the path. One reads the captured event word into a destination register. The other returns from an interrupt: it branches to the saved address and restores interrupt enable from the copy saved at entry. Operations to set and clear interrupt enable are also decoded here. Every other operation passes the decoder's write request through and does not branch. All outputs are registered. An operation presented in one cycle has its result on the outputs after the next rising clock edge.

Top module: `swi_exec_unit`

## Requirements
- R1: While reset is held and right after it, br_taken, rd_we and irq_ack are 0, and int_en is 0.
- R2: op_sel=1 (software interrupt) with op_valid high gives br_taken=1 and br_target=0x0008 on the next cycle.
- R3: A software interrupt saves op_pc+2 as the return address. A later return (op_sel=3) branches to that address.
- R4: A software interrupt records op_imm[7:2], zero-extended to 16 bits, as the event word. Immediate bits 1:0 are ignored. op_sel=2 (get event) then drives rd_we=1 and rd_data equal to that word.
- R5: A software interrupt copies int_en into the saved-enable flag and clears int_en.
- R6: A software interrupt drives rd_we=0 even when dec_we is high.
- R7: irq_req is taken only while int_en is 1. When it is taken: br_taken=1, br_target=0x0008, irq_ack=1 for one cycle, int_en becomes 0, op_pc is saved as the return address, and any operation presented in that cycle is squashed (rd_we=0). While int_en is 0, irq_req has no effect.
- R8: The event word on irq_event is captured in the cycle when irq_ack is high. A following get-event operation returns it, including memory-violation words with 0x80 in the high byte.
- R9: A return operation (op_sel=3) gives br_taken=1 with br_target equal to the saved return address, and loads int_en from the saved-enable flag.
- R10: A software interrupt issued while int_en is 0 still vectors and still overwrites the saved return address. Its saved-enable flag becomes 0, so the matching return leaves int_en at 0.
- R11: op_sel=4 sets int_en and op_sel=5 clears it. op_sel=0 (ordinary operation) gives rd_we=dec_we and br_taken=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Decoded operation class |
| op_imm | input | 8 | Instruction immediate |
| op_pc | input | 16 | Address of the presented instruction |
| dec_we | input | 1 | Decoder's destination write request |
| irq_req | input | 1 | External interrupt request |
| irq_event | input | 16 | Requester's event word, valid while irq_ack is high |
| br_target | output | 16 | Branch target address |
| br_taken | output | 1 | Branch flag |
| rd_we | output | 1 | Destination register write enable |
| rd_data | output | 16 | Event word for a get-event operation |
| irq_ack | output | 1 | Interrupt acknowledge |
| int_en | output | 1 | Current interrupt enable |

## Verification
The embedded properties check on every cycle that interrupt entry clears interrupt enable and raises the acknowledge, that a software interrupt produces the vector with writeback off and saves op_pc plus two, and that a return restores enable from the saved flag. Only the bench scenarios can show the data paths that span several operations. These are the event word that a get-event operation reads after a software or hardware entry, the return target after each kind of entry, the request that is ignored while interrupts are disabled, and a software interrupt that overwrites the saved state while interrupts are disabled.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic [2:0] {
    OP_ALU    = 3'd0,
    OP_SWI    = 3'd1,
    OP_GETEVT = 3'd2,
    OP_RETI   = 3'd3,
    OP_IEON   = 3'd4,
    OP_IEOFF  = 3'd5
  } op_e;
endpackage

// File: rtl/swi_decode.sv
module swi_decode
  import swi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       op_valid,
  input  logic [2:0] op_sel,
  input  logic       irq_req,
  input  logic       ie_q,
  output logic       hw_take,
  output logic       do_swi,
  output logic       do_get,
  output logic       do_reti,
  output logic       do_ieon,
  output logic       do_ieoff,
  output logic       do_pass
);
  logic issue;

  always_comb begin
    hw_take  = irq_req & ie_q;
    issue    = op_valid & ~hw_take;
    do_swi   = 1'b0;
    do_get   = 1'b0;
    do_reti  = 1'b0;
    do_ieon  = 1'b0;
    do_ieoff = 1'b0;
    do_pass  = 1'b0;
    case (op_sel)
      OP_SWI:    do_swi   = issue;
      OP_GETEVT: do_get   = issue;
      OP_RETI:   do_reti  = issue;
      OP_IEON:   do_ieon  = issue;
      OP_IEOFF:  do_ieoff = issue;
      default:   do_pass  = issue;
    endcase
  end

  // R7
  squash_chk: assert property (@(posedge clk) disable iff (rst)
    hw_take |-> !(do_swi || do_get || do_reti || do_pass || do_ieon || do_ieoff));

  // R11
  one_op_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_swi, do_get, do_reti, do_ieon, do_ieoff, do_pass}));
endmodule

// File: rtl/swi_state.sv
module swi_state #(
  parameter int DATA_W     = 16,
  parameter int IMM_W      = 8,
  parameter int EVT_LSB    = 2,
  parameter int EVT_BITS   = 6,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_take,
  input  logic              do_swi,
  input  logic              do_reti,
  input  logic              do_ieon,
  input  logic              do_ieoff,
  input  logic [DATA_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] irq_event,
  output logic              ie_q,
  output logic              pie_q,
  output logic              ack_q,
  output logic [DATA_W-1:0] epc_q,
  output logic [DATA_W-1:0] evt_q
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(INSN_BYTES);

  logic [EVT_BITS-1:0] evt_field;
  logic [DATA_W-1:0]   evt_sw;
  logic                entry;
  logic                unused_imm;

  assign evt_field  = imm[EVT_LSB +: EVT_BITS];
  assign evt_sw     = DATA_W'(evt_field);
  assign entry      = hw_take | do_swi;
  assign unused_imm = ^imm;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q  <= 1'b0;
      pie_q <= 1'b0;
      ack_q <= 1'b0;
      epc_q <= '0;
      evt_q <= '0;
    end else begin
      ack_q <= hw_take;
      if (entry) begin
        pie_q <= ie_q;
        ie_q  <= 1'b0;
      end else if (do_reti) begin
        ie_q  <= pie_q;
      end else if (do_ieon) begin
        ie_q  <= 1'b1;
      end else if (do_ieoff) begin
        ie_q  <= 1'b0;
      end
      if (hw_take)     epc_q <= pc;
      else if (do_swi) epc_q <= pc + STEP;
      if (do_swi)      evt_q <= evt_sw;
      else if (ack_q)  evt_q <= irq_event;
    end
  end

  // R5
  swi_clear_ie_chk: assert property (@(posedge clk) disable iff (rst)
    do_swi |=> !ie_q && pie_q == $past(ie_q));

  // R3
  swi_epc_chk: assert property (@(posedge clk) disable iff (rst)
    do_swi |=> epc_q == $past(pc) + STEP);

  // R7
  hw_entry_chk: assert property (@(posedge clk) disable iff (rst)
    hw_take |=> ack_q && !ie_q && epc_q == $past(pc));

  // R9
  reti_ie_chk: assert property (@(posedge clk) disable iff (rst)
    do_reti |=> ie_q == $past(pie_q));
endmodule

// File: rtl/swi_result.sv
module swi_result #(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] VEC_ADDR = 16'h0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_take,
  input  logic              do_swi,
  input  logic              do_get,
  input  logic              do_reti,
  input  logic              do_pass,
  input  logic              dec_we,
  input  logic [DATA_W-1:0] epc_q,
  input  logic [DATA_W-1:0] evt_q,
  output logic              br_taken_q,
  output logic [DATA_W-1:0] br_target_q,
  output logic              rd_we_q,
  output logic [DATA_W-1:0] rd_data_q
);
  logic              br_d;
  logic [DATA_W-1:0] tgt_d;

  always_comb begin
    br_d  = hw_take | do_swi | do_reti;
    tgt_d = '0;
    if (hw_take | do_swi) tgt_d = VEC_ADDR;
    else if (do_reti)     tgt_d = epc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      br_taken_q  <= 1'b0;
      br_target_q <= '0;
      rd_we_q     <= 1'b0;
      rd_data_q   <= '0;
    end else begin
      br_taken_q  <= br_d;
      br_target_q <= tgt_d;
      rd_we_q     <= do_get | (do_pass & dec_we);
      rd_data_q   <= do_get ? evt_q : '0;
    end
  end

  // R2
  swi_vector_chk: assert property (@(posedge clk) disable iff (rst)
    do_swi |=> br_taken_q && br_target_q == VEC_ADDR);

  // R6
  swi_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (do_swi || hw_take) |=> !rd_we_q);
endmodule

// File: rtl/swi_exec_unit.sv
module swi_exec_unit #(
  parameter int                DATA_W     = 16,
  parameter int                IMM_W      = 8,
  parameter int                EVT_LSB    = 2,
  parameter int                EVT_BITS   = 6,
  parameter int                INSN_BYTES = 2,
  parameter logic [DATA_W-1:0] VEC_ADDR   = 16'h0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_sel,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic [DATA_W-1:0] op_pc,
  input  logic              dec_we,
  input  logic              irq_req,
  input  logic [DATA_W-1:0] irq_event,
  output logic [DATA_W-1:0] br_target,
  output logic              br_taken,
  output logic              rd_we,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_ack,
  output logic              int_en
);
  logic hw_take, do_swi, do_get, do_reti, do_ieon, do_ieoff, do_pass;
  logic ie_q, pie_q, ack_q;
  logic [DATA_W-1:0] epc_q, evt_q;

  swi_decode u_dec (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .irq_req(irq_req), .ie_q(ie_q), .hw_take(hw_take), .do_swi(do_swi),
    .do_get(do_get), .do_reti(do_reti), .do_ieon(do_ieon),
    .do_ieoff(do_ieoff), .do_pass(do_pass)
  );

  swi_state #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .EVT_LSB(EVT_LSB),
    .EVT_BITS(EVT_BITS), .INSN_BYTES(INSN_BYTES)
  ) u_state (
    .clk(clk), .rst(rst), .hw_take(hw_take), .do_swi(do_swi),
    .do_reti(do_reti), .do_ieon(do_ieon), .do_ieoff(do_ieoff),
    .pc(op_pc), .imm(op_imm), .irq_event(irq_event), .ie_q(ie_q),
    .pie_q(pie_q), .ack_q(ack_q), .epc_q(epc_q), .evt_q(evt_q)
  );

  swi_result #(.DATA_W(DATA_W), .VEC_ADDR(VEC_ADDR)) u_res (
    .clk(clk), .rst(rst), .hw_take(hw_take), .do_swi(do_swi),
    .do_get(do_get), .do_reti(do_reti), .do_pass(do_pass),
    .dec_we(dec_we), .epc_q(epc_q), .evt_q(evt_q),
    .br_taken_q(br_taken), .br_target_q(br_target),
    .rd_we_q(rd_we), .rd_data_q(rd_data)
  );

  assign irq_ack = ack_q;
  assign int_en  = ie_q;

  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);
endmodule

// File: tb/swi_exec_unit_tb.sv
module swi_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [7:0]  op_imm = 8'd0;
  logic [15:0] op_pc = 16'd0;
  logic        dec_we = 1'b0;
  logic        irq_req = 1'b0;
  logic [15:0] irq_event = 16'd0;
  logic [15:0] br_target, rd_data;
  logic        br_taken, rd_we, irq_ack, int_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic        br;
    logic [15:0] tgt;
    logic        we;
    logic [15:0] data;
    logic        ack;
    logic        ie;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  swi_exec_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .op_imm(op_imm), .op_pc(op_pc), .dec_we(dec_we), .irq_req(irq_req),
    .irq_event(irq_event), .br_target(br_target), .br_taken(br_taken),
    .rd_we(rd_we), .rd_data(rd_data), .irq_ack(irq_ack), .int_en(int_en)
  );

  function automatic exp_t mk(logic br, logic [15:0] tgt, logic we,
                              logic [15:0] data, logic ack, logic ie);
    exp_t e;
    e.br = br; e.tgt = tgt; e.we = we; e.data = data; e.ack = ack; e.ie = ie;
    return e;
  endfunction

  task automatic compare(exp_t e, string tag);
    exp_t a;
    a = mk(br_taken, br_taken ? br_target : 16'h0, rd_we,
           rd_we ? rd_data : 16'h0, irq_ack, int_en);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual br=%0b tgt=%h we=%0b data=%h ack=%0b ie=%0b expected br=%0b tgt=%h we=%0b data=%h ack=%0b ie=%0b",
               tag, a.br, a.tgt, a.we, a.data, a.ack, a.ie,
               e.br, e.tgt, e.we, e.data, e.ack, e.ie);
    end
  endtask

  // Driver: presents one operation and queues what must appear after the edge.
  task automatic step(logic v, logic [2:0] op, logic [7:0] imm,
                      logic [15:0] pc, logic dwe, logic rq, logic [15:0] ev,
                      exp_t e, string tag);
    @(negedge clk);
    op_valid = v; op_sel = op; op_imm = imm; op_pc = pc;
    dec_we = dwe; irq_req = rq; irq_event = ev;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: pops and compares once the outputs have settled after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs while reset is held
    compare(mk(0, 0, 0, 0, 0, 0), "R1 reset");
    @(negedge clk);
    rst = 1'b0;
    // R1 idle after reset
    step(0, 3'd0, 0, 0, 0, 0, 0, mk(0, 0, 0, 0, 0, 0), "R1 idle");
    // R11 ordinary op passes write request
    step(1, 3'd0, 0, 16'h0010, 1, 0, 0, mk(0, 0, 1, 0, 0, 0), "R11 alu we");
    // R11 enable on
    step(1, 3'd4, 0, 16'h0012, 0, 0, 0, mk(0, 0, 0, 0, 0, 1), "R11 ie on");
    // R2 R5 R6 software interrupt with enable set, decoder wants a write
    step(1, 3'd1, 8'hFF, 16'h0100, 1, 0, 0, mk(1, 16'h0008, 0, 0, 0, 0), "R2 R5 R6 swi");
    // R4 get event: imm[7:2]=0x3F
    step(1, 3'd2, 0, 16'h0008, 1, 0, 0, mk(0, 0, 1, 16'h003F, 0, 0), "R4 getevt max");
    // R3 R9 return to pc+2, enable restored to 1
    step(1, 3'd3, 0, 16'h000A, 0, 0, 0, mk(1, 16'h0102, 0, 0, 0, 1), "R3 R9 reti");
    // R4 low immediate bits ignored: imm=0x03 gives event 0
    step(1, 3'd1, 8'h03, 16'h0120, 0, 0, 0, mk(1, 16'h0008, 0, 0, 0, 0), "R2 swi evt0");
    step(1, 3'd2, 0, 16'h0008, 0, 0, 0, mk(0, 0, 1, 16'h0000, 0, 0), "R4 getevt zero");
    step(1, 3'd3, 0, 16'h000A, 0, 0, 0, mk(1, 16'h0122, 0, 0, 0, 1), "R3 reti 2");
    // R11 enable off
    step(1, 3'd5, 0, 16'h0124, 0, 0, 0, mk(0, 0, 0, 0, 0, 0), "R11 ie off");
    // R7 request ignored while disabled; ordinary op still writes
    step(1, 3'd0, 0, 16'h0126, 1, 1, 16'h1111, mk(0, 0, 1, 0, 0, 0), "R7 masked");
    step(1, 3'd4, 0, 16'h0128, 0, 0, 0, mk(0, 0, 0, 0, 0, 1), "R11 ie on 2");
    // R7 request taken: squashes the presented op, saves op_pc
    step(1, 3'd0, 0, 16'h0200, 1, 1, 16'h2222, mk(1, 16'h0008, 0, 0, 1, 0), "R7 taken");
    // R8 event word valid during acknowledge
    step(0, 3'd0, 0, 16'h0008, 0, 0, 16'h8003, mk(0, 0, 0, 0, 0, 0), "R7 ack drop");
    step(1, 3'd2, 0, 16'h0008, 0, 0, 16'h5555, mk(0, 0, 1, 16'h8003, 0, 0), "R8 hw event");
    // R9 return to interrupted address with enable restored
    step(1, 3'd3, 0, 16'h000A, 0, 0, 0, mk(1, 16'h0200, 0, 0, 0, 1), "R9 reti hw");
    // R10 software interrupt while disabled
    step(1, 3'd5, 0, 16'h0200, 0, 0, 0, mk(0, 0, 0, 0, 0, 0), "R11 ie off 2");
    step(1, 3'd1, 8'h14, 16'h0300, 1, 0, 0, mk(1, 16'h0008, 0, 0, 0, 0), "R10 swi disabled");
    step(1, 3'd2, 0, 16'h0008, 0, 0, 0, mk(0, 0, 1, 16'h0005, 0, 0), "R10 getevt");
    step(1, 3'd3, 0, 16'h000A, 0, 0, 0, mk(1, 16'h0302, 0, 0, 0, 0), "R10 reti stays off");
    step(0, 3'd0, 0, 0, 0, 0, 0, mk(0, 0, 0, 0, 0, 0), "R11 idle end");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule